// File: doc/BRIEF.md
# Tunnel Occupancy Jam Monitor

This block keeps count of how many items are inside a tunnel. One beam sensor watches the entry and one watches the exit. Each sensor reads 1 while an item interrupts its beam. The rising edge of a sensor sets a sticky event flag for that sensor. The two flags are merged into one active-low service request.

A small service sequencer handles pending flags one at a time. An entry event raises the occupancy count and an exit event lowers it. The flag that was handled is then cleared. After each service step the sequencer polls both flags again, and it goes idle only when neither flag is set, so an event that arrives during service is not dropped.

The count is compared against a jam limit after every update, and an active-low alarm is driven while the count is above that limit. A preset input reloads the count after a jam has been cleared. A sticky underflow bit records any exit event that arrives while the count is already zero.

Top module: `occ_jam_monitor`

## Requirements
- R1: A rising edge (0 to 1) on `entry_beam` or `exit_beam` sets that sensor's pending flag. A beam held at 1 gives exactly one event.
- R2: `req_n` is 0 in the cycle after the edge that sets any pending flag. It stays 0 while either flag is pending and returns to 1 once both are clear.
- R3: Servicing an entry event adds one to `occupancy`, and servicing an exit event subtracts one. With the sequencer idle, a single event shows on `occupancy` two clock edges after the edge that set its flag. The count saturates at its maximum value.
- R4: `alarm_n` is 0 when `occupancy` is greater than LIMIT (default 4) and 1 otherwise. It changes on the same edge as `occupancy`.
- R5: The sequencer polls both flags after every service step and goes idle only when both are clear. Every event that occurs during service is eventually counted.
- R6: When both flags are pending, the entry event is serviced first. No more than one flag is cleared in any cycle, and `occupancy` changes by at most one per cycle.
- R7: If a sensor's rising edge lands in the same cycle as the clear of that sensor's flag, the flag stays set and the new event is serviced later.
- R8: An exit event serviced while `occupancy` is 0 leaves the count at 0 and sets `underflow`, which stays 1.
- R9: `preset_load` loads `preset_value` into `occupancy` on the next edge, clears `underflow`, and updates `alarm_n`. A service step in that same cycle is dropped.
- R10: After reset, `occupancy` is 0, `underflow` is 0, `alarm_n` is 1 and `req_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_beam | input | 1 | Entry sensor, 1 while beam broken |
| exit_beam | input | 1 | Exit sensor, 1 while beam broken |
| preset_load | input | 1 | Load `preset_value` into the count |
| preset_value | input | CNT_W | Value loaded by preset |
| alarm_n | output | 1 | Active-low jam alarm |
| occupancy | output | CNT_W | Items currently inside |
| underflow | output | 1 | Sticky: an exit was seen at zero count |
| req_n | output | 1 | Active-low pending-service request |

## Verification
A flag that is lost or stuck shows up at the ports in one of two ways: `req_n` stays high after an edge, or `req_n` stays low forever. In the first case, `occupancy` also ends up one step short of the bench model within a few cycles. A sequencer that gives up after one step, or that services both flags at once, makes the final count disagree with the model once simultaneous events or events landing during service have been applied. A wrong compare or a wrong saturation shows on `alarm_n` or `underflow` on the same edge that the count changes.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SERVE = 2'd1,
    SEQ_POLL  = 2'd2
  } seq_state_t;

  localparam int SNS_ENTRY = 0;
  localparam int SNS_EXIT  = 1;
  localparam int NUM_SNS   = 2;
endpackage

// File: rtl/occ_edge_flag.sv
module occ_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic beam,
  input  logic clr,
  output logic flag
);
  logic beam_q;
  logic rise;

  assign rise = beam & ~beam_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beam_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      beam_q <= beam;
      flag   <= rise | (flag & ~clr);
    end
  end

  // R1
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (beam && !beam_q) |=> flag);
endmodule

// File: rtl/occ_svc_seq.sv
module occ_svc_seq
  import occ_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flag_in,
  input  logic flag_out,
  output logic clr_in,
  output logic clr_out,
  output logic inc,
  output logic dec
);
  seq_state_t state, state_nxt;
  logic pick_in;

  assign pick_in = flag_in;

  always_comb begin
    state_nxt = state;
    case (state)
      SEQ_IDLE:  if (flag_in || flag_out) state_nxt = SEQ_SERVE;
      SEQ_SERVE: state_nxt = SEQ_POLL;
      SEQ_POLL:  state_nxt = (flag_in || flag_out) ? SEQ_SERVE : SEQ_IDLE;
      default:   state_nxt = SEQ_IDLE;
    endcase
  end

  always_comb begin
    clr_in  = 1'b0;
    clr_out = 1'b0;
    if (state == SEQ_SERVE) begin
      if (pick_in) clr_in = 1'b1;
      else if (flag_out) clr_out = 1'b1;
    end
    inc = clr_in;
    dec = clr_out;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_IDLE;
    else     state <= state_nxt;
  end

  // R6
  one_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_in, clr_out}));

  // R6
  entry_first_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_SERVE && flag_in) |-> !clr_out);

  // R5
  no_early_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_POLL && (flag_in || flag_out)) |=> state == SEQ_SERVE);
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic             preset_load,
  input  logic [CNT_W-1:0] preset_value,
  output logic [CNT_W-1:0] count,
  output logic             alarm_n,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_nxt;
  logic             uf_nxt;

  always_comb begin
    cnt_nxt = count;
    uf_nxt  = underflow;
    if (preset_load) begin
      cnt_nxt = preset_value;
      uf_nxt  = 1'b0;
    end else if (inc) begin
      if (count != MAX_V) cnt_nxt = count + 1'b1;
    end else if (dec) begin
      if (count == '0) uf_nxt = 1'b1;
      else cnt_nxt = count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      underflow <= 1'b0;
      alarm_n   <= 1'b1;
    end else begin
      count     <= cnt_nxt;
      underflow <= uf_nxt;
      alarm_n   <= !(cnt_nxt > LIM_V);
    end
  end

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !preset_load && count != MAX_V) |=> count == $past(count) + 1'b1);

  // R8
  floor_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !preset_load && count == '0) |=> (count == '0 && underflow));

  // R4
  alarm_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_n == !(count > LIM_V));

  // R9
  preset_chk: assert property (@(posedge clk) disable iff (rst)
    preset_load |=> (count == $past(preset_value) && !underflow));
endmodule

// File: rtl/occ_jam_monitor.sv
module occ_jam_monitor
  import occ_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entry_beam,
  input  logic             exit_beam,
  input  logic             preset_load,
  input  logic [CNT_W-1:0] preset_value,
  output logic             alarm_n,
  output logic [CNT_W-1:0] occupancy,
  output logic             underflow,
  output logic             req_n
);
  logic [NUM_SNS-1:0] beams;
  logic [NUM_SNS-1:0] flags;
  logic [NUM_SNS-1:0] clrs;
  logic               inc, dec;

  assign beams[SNS_ENTRY] = entry_beam;
  assign beams[SNS_EXIT]  = exit_beam;

  for (genvar g = 0; g < NUM_SNS; g++) begin : g_sns
    occ_edge_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .beam (beams[g]),
      .clr  (clrs[g]),
      .flag (flags[g])
    );
  end

  assign req_n = ~|flags;

  occ_svc_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .flag_in  (flags[SNS_ENTRY]),
    .flag_out (flags[SNS_EXIT]),
    .clr_in   (clrs[SNS_ENTRY]),
    .clr_out  (clrs[SNS_EXIT]),
    .inc      (inc),
    .dec      (dec)
  );

  occ_counter #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .inc          (inc),
    .dec          (dec),
    .preset_load  (preset_load),
    .preset_value (preset_value),
    .count        (occupancy),
    .alarm_n      (alarm_n),
    .underflow    (underflow)
  );

  // R2
  req_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_n) |-> (flags != '0));

  // R6
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!preset_load && !$past(preset_load) && !$past(rst)) |->
      (occupancy == $past(occupancy) || occupancy == $past(occupancy) + 1'b1 ||
       occupancy == $past(occupancy) - 1'b1));
endmodule

// File: tb/occ_jam_monitor_tb.sv
module occ_jam_monitor_tb;
  localparam int CNT_W = 8;
  localparam int LIMIT = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             entry_beam = 1'b0;
  logic             exit_beam = 1'b0;
  logic             preset_load = 1'b0;
  logic [CNT_W-1:0] preset_value = '0;
  logic             alarm_n;
  logic [CNT_W-1:0] occupancy;
  logic             underflow;
  logic             req_n;

  always #2 clk = ~clk;

  occ_jam_monitor #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst(rst), .entry_beam(entry_beam), .exit_beam(exit_beam),
    .preset_load(preset_load), .preset_value(preset_value),
    .alarm_n(alarm_n), .occupancy(occupancy), .underflow(underflow), .req_n(req_n)
  );

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             al_n;
    logic             uf;
    logic [7:0]       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   sample_req = 1'b0;
  bit   done = 1'b0;
  int   m_cnt = 0;
  bit   m_uf = 1'b0;

  task automatic check1(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_in();
    if (m_cnt < 255) m_cnt++;
  endtask
  task automatic model_out();
    if (m_cnt == 0) m_uf = 1'b1; else m_cnt--;
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_now(input logic [7:0] tag);
    exp_t e;
    e.cnt  = CNT_W'(m_cnt);
    e.al_n = !(m_cnt > LIMIT);
    e.uf   = m_uf;
    e.tag  = tag;
    exp_q.push_back(e);
    settle();
    sample_req = 1'b1;
    wait (sample_req == 1'b0);
  endtask

  task automatic pulse_entry();
    @(negedge clk); entry_beam = 1'b1;
    @(negedge clk); entry_beam = 1'b0;
    model_in();
  endtask
  task automatic pulse_exit();
    @(negedge clk); exit_beam = 1'b1;
    @(negedge clk); exit_beam = 1'b0;
    model_out();
  endtask

  // monitor: pops the scoreboard when the driver asks
  initial begin
    forever begin
      @(negedge clk);
      if (sample_req && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        $display("check tag R%0d", e.tag);
        check1("R3/R5 occupancy", 32'(occupancy), 32'(e.cnt));
        check1("R4 alarm_n", 32'(alarm_n), 32'(e.al_n));
        check1("R8/R9 underflow", 32'(underflow), 32'(e.uf));
        check1("R5 req_n idle", 32'(req_n), 32'd1);
        sample_req = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    check1("R10 occupancy", 32'(occupancy), 0);
    check1("R10 alarm_n", 32'(alarm_n), 1);
    check1("R10 underflow", 32'(underflow), 0);
    check1("R10 req_n", 32'(req_n), 1);

    // R8 exit at zero count
    pulse_exit();
    expect_now(8'd8);

    // R9 preset clears underflow
    @(negedge clk); preset_value = 8'd0; preset_load = 1'b1;
    @(negedge clk); preset_load = 1'b0;
    m_cnt = 0; m_uf = 1'b0;
    expect_now(8'd9);

    // R2 request timing and R3 latency
    @(negedge clk); entry_beam = 1'b1;
    @(posedge clk); @(negedge clk);
    check1("R2 req_n low", 32'(req_n), 0);
    check1("R3 not yet", 32'(occupancy), 0);
    @(posedge clk); @(negedge clk);
    check1("R3 still old", 32'(occupancy), 0);
    @(posedge clk); @(negedge clk);
    check1("R3 updated", 32'(occupancy), 1);
    check1("R2 req_n high", 32'(req_n), 1);
    model_in();
    // R1 held beam counts once
    repeat (6) @(negedge clk);
    entry_beam = 1'b0;
    expect_now(8'd1);

    // R4 boundary at LIMIT, then above
    for (int i = 0; i < 3; i++) pulse_entry();
    expect_now(8'd4);
    pulse_entry();
    expect_now(8'd4);
    pulse_exit();
    expect_now(8'd4);

    // R6 simultaneous: entry first
    @(negedge clk); entry_beam = 1'b1; exit_beam = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check1("R6 entry first", 32'(occupancy), 32'(m_cnt + 1));
    entry_beam = 1'b0; exit_beam = 1'b0;
    model_in(); model_out();
    expect_now(8'd6);

    // R7 new edge coinciding with clear
    @(negedge clk); entry_beam = 1'b1;
    @(negedge clk); entry_beam = 1'b0;
    @(negedge clk); entry_beam = 1'b1;
    @(negedge clk); entry_beam = 1'b0;
    model_in(); model_in();
    expect_now(8'd7);

    // R5 exit arriving during entry service
    @(negedge clk); entry_beam = 1'b1;
    @(negedge clk); entry_beam = 1'b0;
    @(negedge clk); exit_beam = 1'b1;
    @(negedge clk); exit_beam = 1'b0;
    model_in(); model_out();
    expect_now(8'd5);

    // R9 preset dominates a service step, raises alarm
    @(negedge clk); entry_beam = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    preset_value = 8'd7; preset_load = 1'b1;
    @(negedge clk); preset_load = 1'b0; entry_beam = 1'b0;
    m_cnt = 7; m_uf = 1'b0;
    expect_now(8'd9);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule